// File: doc/BRIEF.md
# Serial Register Slave with Write-Enable Gating

This block is the two-wire serial slave front end of a small byte-wide register file. SCL and SDA are sampled by a faster system clock through synchronizers. Edges on the synchronized lines detect START and STOP and mark the points where bits are taken in and sent out. A transaction opens with a device byte: a fixed 4-bit identifier, three bits that must match the strap pins, and a direction bit. A write then carries a register pointer byte and any number of data bytes. A read returns bytes from the pointer onwards. The pointer advances after every byte that is accepted or sent.

Whether a data byte is acknowledged is decided byte by byte. An internal write-enable latch must be set, with one exception: the unlock register at 86h is always writable, and its bit 1 is the latch. A data byte addressed to 80h, 85h or 86h locks the rest of the transaction, so every later data byte is refused until the next START. Writes reach the parent as a single-cycle strobe. Reads use a combinational lookup of `reg_rd_data_i` at `reg_rd_addr_o`.

States and transitions of the controller:
- `ST_IDLE`: released, waiting. Any START → `ST_DEVADR`.
- `ST_DEVADR`: collects 8 bits. On the falling edge after the 8th bit: → `ST_DEVACK` on a match, → `ST_IGNORE` otherwise.
- `ST_DEVACK`: on the falling edge: → `ST_RDDATA` if reading, else → `ST_REGADR`.
- `ST_REGADR` → `ST_REGACK` → `ST_WRDATA`: the pointer byte is always acknowledged.
- `ST_WRDATA` ↔ `ST_WRACK`: one lap per data byte.
- `ST_RDDATA` → `ST_RDACK`: on the falling edge, an ACK from the master → `ST_RDDATA`, a NACK → `ST_IGNORE`.
- `ST_IGNORE`: released until the next START or STOP.
- From any state, START → `ST_DEVADR` and STOP → `ST_IDLE`.

Top module: `rs_serial_slave`

## Requirements
- R1: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. Before the first START the block never drives SDA and never writes.
- R2: After reset `sda_oe_o` is 0 and `reg_wr_en_o` is 0.
- R3: A device byte is acknowledged only when bits 7:4 are 1010 and bits 3:1 equal `strap_i[2:0]`. Bit 0 is the direction: 1 means read. Any other device byte is not acknowledged, and the block then neither drives SDA nor writes until the next START.
- R4: In a write, the byte after the device byte is always acknowledged and loads the register pointer, which is visible on `reg_rd_addr_o`.
- R5: While the write-enable latch is 0, a data byte to any address other than 86h is not acknowledged and produces no write strobe. The latch is 0 after reset.
- R6: A data byte to address 86h is accepted whatever the latch holds, unless the transaction is locked (R8). Bit 1 of that byte becomes the new latch value.
- R7: An accepted data byte is acknowledged and written with a one-cycle `reg_wr_en_o` pulse. The pulse carries the pointer on `reg_wr_addr_o` and the byte on `reg_wr_data_o`. The pointer then advances by one. A refused byte leaves the pointer unchanged.
- R8: After any data byte addressed to 80h, 85h or 86h, accepted or not, every later data byte of the same transaction is refused and not written. A START clears this lock.
- R9: In a read, each byte is `reg_rd_data_i` at the pointer, sent most significant bit first, and the pointer advances per byte. An ACK from the master on the ninth clock continues with the next byte. A NACK leaves SDA released until the next START or STOP.
- R10: A STOP returns the block to idle with SDA released. After it, bus traffic is ignored until a START.
- R11: An acknowledge drives SDA low through the ninth SCL high phase. SDA is released after the following SCL fall. `sda_oe_o` changes only after an SCL fall, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Device address strap pins |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_wr_en_o | output | 1 | One-cycle register write strobe |
| reg_wr_addr_o | output | 8 | Address of the register being written |
| reg_wr_data_o | output | 8 | Data being written |
| reg_rd_addr_o | output | 8 | Current register pointer, used for reads |
| reg_rd_data_i | input | 8 | Register contents at `reg_rd_addr_o` |

## Verification
The hardest situation to reach from the ports is the interaction of the latch with the special-address lock. A refused byte must not advance the pointer, a byte to 86h must both unlock and lock, and a fresh START must clear the lock but not the latch. The bench reaches this by ordering whole transactions: latch clear, then set through 86h, then bursts that cross 80h and 85h, then cleared again. It compares the acknowledge on each ninth clock and the modelled register contents against values computed from the address arithmetic. The device byte is swept over every strap setting against every address, plus every wrong identifier.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_REGADR,
        ST_REGACK,
        ST_WRDATA,
        ST_WRACK,
        ST_RDDATA,
        ST_RDACK,
        ST_IGNORE
    } rs_state_e;

    localparam logic [3:0] RS_DEV_ID = 4'b1010;
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe[s] <= '1;
            end else begin
                pipe[s] <= (s == 0) ? d_i : pipe[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rs_bus_cond.sv
module rs_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/rs_ack_policy.sv
module rs_ack_policy #(
    parameter int          AW          = 8,
    parameter logic [7:0]  UNLOCK_ADDR = 8'h86,
    parameter logic [7:0]  SPC_A       = 8'h80,
    parameter logic [7:0]  SPC_B       = 8'h85
) (
    input  logic [AW-1:0] ptr,
    input  logic          latch,
    input  logic          locked,
    output logic          accept,
    output logic          special
);
    logic at_unlock;

    assign at_unlock = (ptr == AW'(UNLOCK_ADDR));
    assign special   = at_unlock || (ptr == AW'(SPC_A)) || (ptr == AW'(SPC_B));
    assign accept    = !locked && (latch || at_unlock);
endmodule

// File: rtl/rs_serial_slave.sv
module rs_serial_slave
    import rs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         LATCH_BIT   = 1,
    parameter logic [7:0] UNLOCK_ADDR = 8'h86,
    parameter logic [7:0] SPC_A       = 8'h80,
    parameter logic [7:0] SPC_B       = 8'h85
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe_o,
    output logic       reg_wr_en_o,
    output logic [7:0] reg_wr_addr_o,
    output logic [7:0] reg_wr_data_o,
    output logic [7:0] reg_rd_addr_o,
    input  logic [7:0] reg_rd_data_i
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    logic [1:0] bus_s;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    rs_state_e state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_W-1:0] shreg, ptr;
    logic [BYTE_W-2:0] tx;
    logic rw, latch, locked, ack_seen, accept, special, dev_match, byte_done;

    rs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    rs_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    rs_ack_policy #(.AW(BYTE_W), .UNLOCK_ADDR(UNLOCK_ADDR), .SPC_A(SPC_A), .SPC_B(SPC_B)) u_policy (
        .ptr(ptr), .latch(latch), .locked(locked), .accept(accept), .special(special)
    );

    assign dev_match = (shreg[7:4] == RS_DEV_ID) && (shreg[3:1] == strap_i);
    assign byte_done = scl_fall && (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_DEVADR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_IDLE;
                ST_DEVADR: if (byte_done) nxt = dev_match ? ST_DEVACK : ST_IGNORE;
                ST_DEVACK: if (scl_fall)  nxt = rw ? ST_RDDATA : ST_REGADR;
                ST_REGADR: if (byte_done) nxt = ST_REGACK;
                ST_REGACK: if (scl_fall)  nxt = ST_WRDATA;
                ST_WRDATA: if (byte_done) nxt = ST_WRACK;
                ST_WRACK:  if (scl_fall)  nxt = ST_WRDATA;
                ST_RDDATA: if (byte_done) nxt = ST_RDACK;
                ST_RDACK:  if (scl_fall)  nxt = ack_seen ? ST_RDDATA : ST_IGNORE;
                ST_IGNORE: nxt = ST_IGNORE;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
            rw <= 1'b0; latch <= 1'b0; locked <= 1'b0; ack_seen <= 1'b0;
            sda_oe_o <= 1'b0; reg_wr_en_o <= 1'b0;
            reg_wr_addr_o <= '0; reg_wr_data_o <= '0;
        end else if (start_det) begin
            cnt <= '0; sda_oe_o <= 1'b0; locked <= 1'b0; reg_wr_en_o <= 1'b0;
        end else if (stop_det) begin
            cnt <= '0; sda_oe_o <= 1'b0; reg_wr_en_o <= 1'b0;
        end else begin
            reg_wr_en_o <= 1'b0;
            if (scl_rise) begin
                unique case (state)
                    ST_DEVADR, ST_REGADR, ST_WRDATA: begin
                        shreg <= {shreg[BYTE_W-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end
                    ST_RDDATA: cnt <= cnt + 1'b1;
                    ST_RDACK:  ack_seen <= !sda_s;
                    default:   ;
                endcase
            end
            if (scl_fall) begin
                unique case (state)
                    ST_DEVADR: if (cnt == LAST) begin
                        sda_oe_o <= dev_match;
                        rw       <= shreg[0];
                        cnt      <= '0;
                    end
                    ST_DEVACK, ST_RDACK: begin
                        cnt <= '0;
                        if ((state == ST_DEVACK && rw) || (state == ST_RDACK && ack_seen)) begin
                            tx       <= reg_rd_data_i[BYTE_W-2:0];
                            sda_oe_o <= !reg_rd_data_i[BYTE_W-1];
                            ptr      <= ptr + 1'b1;
                        end else begin
                            sda_oe_o <= 1'b0;
                        end
                    end
                    ST_REGADR: if (cnt == LAST) begin
                        sda_oe_o <= 1'b1;
                        ptr      <= shreg;
                        cnt      <= '0;
                    end
                    ST_WRDATA: if (cnt == LAST) begin
                        sda_oe_o      <= accept;
                        reg_wr_en_o   <= accept;
                        reg_wr_addr_o <= ptr;
                        reg_wr_data_o <= shreg;
                        cnt           <= '0;
                        if (accept) ptr <= ptr + 1'b1;
                        if (accept && ptr == UNLOCK_ADDR) latch <= shreg[LATCH_BIT];
                        if (special) locked <= 1'b1;
                    end
                    ST_RDDATA: begin
                        if (cnt == LAST) begin
                            sda_oe_o <= 1'b0;
                        end else begin
                            sda_oe_o <= !tx[BYTE_W-2];
                            tx       <= {tx[BYTE_W-3:0], 1'b0};
                        end
                    end
                    ST_REGACK, ST_WRACK: sda_oe_o <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assign reg_rd_addr_o = ptr;
endmodule

// File: rtl/rs_serial_slave_chk.sv
module rs_serial_slave_chk
    import rs_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sda_oe,
    input logic      wr_en,
    input rs_state_e state,
    input logic      start_det,
    input logic      stop_det,
    input logic      scl_fall,
    input logic      locked
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_oe && !wr_en));

    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_oe && !wr_en));

    p_write_acked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);

    p_write_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    p_locked_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(locked));

    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    p_oe_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));
endmodule

bind rs_serial_slave rs_serial_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .wr_en(reg_wr_en_o),
    .state(state), .start_det(start_det), .stop_det(stop_det),
    .scl_fall(scl_fall), .locked(locked)
);

// File: tb/tb_rs_serial_slave.sv
`timescale 1ns/1ps
module tb_rs_serial_slave;
    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_oe, wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic [7:0] mem [256];
    int wr_count = 0;
    int vectors = 0, miscompares = 0;
    bit done = 0;
    wire sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    rs_serial_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
        .sda_oe_o(sda_oe), .reg_wr_en_o(wr_en), .reg_wr_addr_o(wr_addr),
        .reg_wr_data_o(wr_data), .reg_rd_addr_o(rd_addr), .reg_rd_data_i(rd_data)
    );

    assign rd_data = mem[rd_addr];

    always @(posedge clk) if (wr_en) begin
        mem[wr_addr] <= wr_data;
        wr_count <= wr_count + 1;
    end

    function automatic logic [7:0] init_val(input int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(); scl = 1'b1; tick(); sda_m = 1'b0; tick(); scl = 1'b0; tick();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(); scl = 1'b1; tick(); sda_m = 1'b1; tick();
    endtask

    // send a byte, return whether the slave pulled SDA low in the ninth high phase
    task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(); scl = 1'b1; tick(); scl = 1'b0; tick();
        end
        sda_m = 1'b1; tick(); scl = 1'b1;
        repeat (5) @(negedge clk);
        ack = ~sda_line;
        repeat (5) @(negedge clk);
        scl = 1'b0; tick();
        rel = ~sda_oe;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(); scl = 1'b1;
            repeat (5) @(negedge clk);
            b[i] = sda_line;
            repeat (5) @(negedge clk);
            scl = 1'b0; tick();
        end
        sda_m = ~give_ack; tick(); scl = 1'b1; tick(); scl = 1'b0; tick(); sda_m = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vectors++; miscompares++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic ack, rel;
        logic [7:0] rb;
        int wc;
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        repeat (5) @(negedge clk);
        // R2: reset state
        check("R2 sda_oe in reset", sda_oe, 0);
        check("R2 wr_en in reset", wr_en, 0);
        rst_n = 1'b1;
        tick();
        check("R2 sda_oe after reset", sda_oe, 0);

        // R1: traffic before any START is ignored
        send_byte(8'hAA, ack, rel);
        check("R1 no ack before START", ack, 0);
        send_byte(8'h20, ack, rel);
        check("R1 no ack before START (2nd)", ack, 0);
        check("R1 no write before START", wr_count, 0);

        // R3: sweep straps against every device address, R/W=0
        for (int st = 0; st < 8; st++) begin
            strap = 3'(st);
            for (int da = 0; da < 8; da++) begin
                bus_start();
                send_byte({4'b1010, 3'(da), 1'b0}, ack, rel);
                check("R3 device address match", ack, (da == st) ? 1 : 0);
                if (da != st) begin
                    send_byte(8'h86, ack, rel);
                    check("R3 silent after mismatch", ack, 0);
                end
                bus_stop();
            end
        end
        // R3: every wrong identifier with a matching strap
        strap = 3'b101;
        for (int id = 0; id < 16; id++) begin
            if (id == 10) continue;
            bus_start();
            send_byte({4'(id), 3'b101, 1'b0}, ack, rel);
            check("R3 wrong identifier", ack, 0);
            bus_stop();
        end
        check("R3 no writes during sweep", wr_count, 0);

        // R4/R5: latch clear, data refused everywhere except 86h
        foreach (rb[k]) ;
        for (int j = 0; j < 5; j++) begin
            logic [7:0] a;
            a = (j == 0) ? 8'h00 : (j == 1) ? 8'h3C : (j == 2) ? 8'h80 : (j == 3) ? 8'h85 : 8'hFF;
            bus_start();
            send_byte(8'hAA, ack, rel);
            check("R3 device ack", ack, 1);
            send_byte(a, ack, rel);
            check("R4 register byte ack", ack, 1);
            check("R4 pointer loaded", rd_addr, a);
            check("R11 released after ack", rel, 1);
            send_byte(8'h5C, ack, rel);
            check("R5 data nack with latch clear", ack, 0);
            check("R7 refused byte keeps pointer", rd_addr, a);
            bus_stop();
            check("R5 register unchanged", mem[a], init_val(a));
        end
        check("R5 no write strobe", wr_count, 0);

        // R6/R8: unlock register, then lock
        bus_start();
        send_byte(8'hAA, ack, rel);
        send_byte(8'h86, ack, rel);
        send_byte(8'h02, ack, rel);
        check("R6 unlock byte acked", ack, 1);
        send_byte(8'h77, ack, rel);
        check("R8 byte after 86h refused", ack, 0);
        bus_stop();
        check("R6 unlock register written", mem[8'h86], 8'h02);
        check("R8 87h untouched", mem[8'h87], init_val(8'h87));
        check("R6 one write", wr_count, 1);

        // R7: latch set, burst with auto increment
        bus_start();
        send_byte(8'hAA, ack, rel);
        send_byte(8'h20, ack, rel);
        for (int k = 0; k < 3; k++) begin
            send_byte(8'(8'h11 * (k + 1)), ack, rel);
            check("R7 burst byte acked", ack, 1);
        end
        check("R7 pointer advanced", rd_addr, 8'h23);
        bus_stop();
        for (int k = 0; k < 3; k++)
            check("R7 burst data", mem[8'h20 + k], 8'(8'h11 * (k + 1)));
        check("R7 write count", wr_count, 4);

        // R8: crossing 85h, then crossing 80h
        bus_start();
        send_byte(8'hAA, ack, rel);
        send_byte(8'h84, ack, rel);
        send_byte(8'h44, ack, rel); check("R8 84h acked", ack, 1);
        send_byte(8'h55, ack, rel); check("R8 85h acked", ack, 1);
        send_byte(8'h66, ack, rel); check("R8 after 85h refused", ack, 0);
        bus_stop();
        check("R8 85h data", mem[8'h85], 8'h55);
        check("R8 86h untouched", mem[8'h86], 8'h02);
        bus_start();
        send_byte(8'hAA, ack, rel);
        send_byte(8'h7F, ack, rel);
        send_byte(8'h01, ack, rel); check("R8 7Fh acked", ack, 1);
        send_byte(8'h02, ack, rel); check("R8 80h acked", ack, 1);
        send_byte(8'h03, ack, rel); check("R8 after 80h refused", ack, 0);
        // repeated START clears the lock
        bus_start();
        send_byte(8'hAA, ack, rel);
        send_byte(8'h90, ack, rel);
        send_byte(8'h9A, ack, rel); check("R8 lock cleared by START", ack, 1);
        bus_stop();
        check("R8 81h untouched", mem[8'h81], init_val(8'h81));
        check("R8 90h written", mem[8'h90], 8'h9A);

        // R9: read three bytes from 30h, then past a NACK
        bus_start();
        send_byte(8'hAA, ack, rel);
        send_byte(8'h30, ack, rel);
        bus_start();
        send_byte(8'hAB, ack, rel);
        check("R9 read address acked", ack, 1);
        recv_byte(rb, 1'b1); check("R9 read byte 0", rb, init_val(8'h30));
        recv_byte(rb, 1'b1); check("R9 read byte 1", rb, init_val(8'h31));
        recv_byte(rb, 1'b0); check("R9 read byte 2", rb, init_val(8'h32));
        check("R9 pointer after read", rd_addr, 8'h33);
        recv_byte(rb, 1'b1); check("R9 released after NACK", rb, 8'hFF);
        bus_stop();
        check("R10 released after STOP", sda_oe, 0);

        // R10: STOP mid-write, then traffic without START
        wc = wr_count;
        bus_start();
        send_byte(8'hAA, ack, rel);
        send_byte(8'h40, ack, rel);
        bus_stop();
        send_byte(8'hAA, ack, rel);
        check("R10 ignored after STOP", ack, 0);
        check("R10 no write after STOP", wr_count, wc);

        // R6/R5: clear the latch through 86h while set, then refused
        bus_start();
        send_byte(8'hAA, ack, rel);
        send_byte(8'h86, ack, rel);
        send_byte(8'h00, ack, rel);
        check("R6 latch clear byte acked", ack, 1);
        bus_stop();
        bus_start();
        send_byte(8'hAA, ack, rel);
        send_byte(8'h20, ack, rel);
        send_byte(8'h99, ack, rel);
        check("R5 refused after latch cleared", ack, 0);
        bus_stop();
        check("R5 20h keeps data", mem[8'h20], 8'h11);

        done = 1;
        summary();
    end
endmodule